// File: doc/BRIEF.md
# Serial Nonvolatile Word-Memory Control Engine

This block models the control logic of a small serial memory built from 128 words of 8 bits. A host loads a 16-bit frame bit by bit through a serial data input, clocked by a serial clock line, while the chip select is high (deselected). The frame holds a data byte followed by a control byte. The control byte carries an arm bit and a 7-bit word address. The frame register keeps its contents while the chip is selected and across later selections, until new bits are clocked in.

Selecting the chip by pulling the chip select low starts a programming cycle. It proceeds only if the arm bit of the stored frame is 1. The level of the data line at that moment picks the operation: high means erase (the addressed word becomes all ones), low means write (the word is ANDed with the frame's data byte). The line must hold that level until the end of a single start pulse on the serial clock. Busy is raised at the falling edge of the start pulse, and the array is updated in the cycle where the chip select returns high. A bulk-erase pin, combined with address 0 and an erase, sets every word to ones. Because the frame persists, an erase can be followed by a write of the same stored data with no new entry. A read port gives combinational access to the array contents.

All inputs are treated as synchronous to `clk`. Their edges are found by comparing each input with its value in the previous cycle.

Top module: `nvw_ctrl`

## Requirements
- R1: After reset, busy and err are 0 and every array word reads 8'hFF.
- R2: While cs_n is 1, each rising edge of sclk shifts sdi into a 16-bit frame. The data byte is sent first, then the control byte, each most significant bit first. The control byte's bit 7 is the arm bit and its bits 6..0 are the word address.
- R3: If the arm bit is 0 when cs_n falls, the selection has no effect: busy stays 0 and the array is unchanged.
- R4: The level of sdi sampled in the cycle where cs_n falls selects the operation: 1 means erase, 0 means write.
- R5: Busy rises in the cycle after the sclk falling edge of the first pulse on an armed selection. It stays high, whatever sclk does, until the cycle after cs_n rises.
- R6: An erase sets the addressed word to 8'hFF.
- R7: A write sets the addressed word to its old value ANDed with the frame's data byte.
- R8: The frame survives deselect and selection, so a second selection can run another operation on the same address and data without new shifting.
- R9: If bulk_en is 1 when cs_n falls, and the operation is an erase to address 0, every word becomes 8'hFF. With bulk_en at 1, a write behaves as a normal write.
- R10: If sdi differs from its captured level at any cycle after cs_n falls and before the start pulse's falling edge, the operation is abandoned. In that case err goes to 1, busy stays 0 and the array is unchanged. Err returns to 0 the cycle after cs_n rises.
- R11: The array changes only in the cycle where cs_n rises while busy is high, and only the addressed word (or all words, for a bulk erase) changes.
- R12: rd_data shows the word at rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Chip select, active low; high means deselected |
| sclk | input | 1 | Serial shift clock and start-pulse line |
| sdi | input | 1 | Serial data and operation-select line |
| bulk_en | input | 1 | Whole-array erase enable |
| rd_addr | input | 7 | Read-port word address |
| rd_data | output | 8 | Read-port word contents |
| busy | output | 1 | Programming in progress |
| err | output | 1 | Operation abandoned because sdi moved |

## Verification
The bench goes after the data-line level as the operation selector. A design that latched it at the wrong moment would erase where a write was meant, and the erase-then-write sequence exposes this. It checks that the write is an AND and not a plain copy, by writing twice to one word; a copying design would leave the second data byte intact. It covers an unarmed selection, an sdi change before the start pulse, and extra sclk pulses while busy. A design that ignored these would alter a word, raise busy, or shift the frame mid-operation. Bulk erase is checked at both ends of the array, and a bulk-enabled write is checked against an unrelated word. A design that widened every operation would wipe words it should leave alone.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 1 + ADDR_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PULSE,
        ST_PROG,
        ST_HALT
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    mode_erase;
        logic    bulk;
        logic    err;
        logic    cs_prev;
        logic    sclk_prev;
    } seq_reg_t;
endpackage

// File: rtl/nvw_shreg.sv
module nvw_shreg #(
    parameter int FRAME_W = nvw_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdi,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en)
            sr_d = {sr_q[FRAME_W-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign frame = sr_q;

    // R2: a shift moves the frame up by one and takes sdi at the bottom
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q[0] == $past(sdi)) &&
                     (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])));

    // R8: without a shift the frame is retained
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/nvw_seq.sv
module nvw_seq
    import nvw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    input  logic bulk_en,
    input  logic cb,
    output logic shift_en,
    output logic commit,
    output logic op_erase,
    output logic op_bulk,
    output logic busy,
    output logic err
);
    seq_reg_t r_d, r_q;
    logic cs_fall, sclk_rise, sclk_fall, moved;

    always_comb begin
        r_d           = r_q;
        r_d.cs_prev   = cs_n;
        r_d.sclk_prev = sclk;
        cs_fall   = r_q.cs_prev && !cs_n;
        sclk_rise = sclk && !r_q.sclk_prev;
        sclk_fall = !sclk && r_q.sclk_prev;
        moved     = (sdi != r_q.mode_erase);
        shift_en  = cs_n && sclk_rise;
        commit    = 1'b0;

        if (cs_n) begin
            commit = (r_q.st == ST_PROG);
            r_d.st  = ST_IDLE;
            r_d.err = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (cs_fall) begin
                        r_d.mode_erase = sdi;
                        r_d.bulk       = bulk_en;
                        r_d.st         = cb ? ST_ARMED : ST_HALT;
                    end
                end
                ST_ARMED: begin
                    if (moved) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HALT;
                    end else if (sclk_rise) begin
                        r_d.st = ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (moved) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HALT;
                    end else if (sclk_fall) begin
                        r_d.st = ST_PROG;
                    end
                end
                ST_PROG: r_d.st = ST_PROG;
                ST_HALT: r_d.st = ST_HALT;
                default: r_d.st = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q            <= '0;
            r_q.st         <= ST_IDLE;
            r_q.cs_prev    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st == ST_PROG);
    assign err      = r_q.err;
    assign op_erase = r_q.mode_erase;
    assign op_bulk  = r_q.bulk;

    // R5: once programming, only a deselect ends it
    p_prog_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cs_n) |=> busy);

    // R5: busy is only entered from the start-pulse state
    p_busy_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(r_q.st) == ST_PULSE));

    // R10: deselect clears both flags in the next cycle
    p_deselect_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!err && !busy));

    // R10: an abandoned operation never shows busy
    p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && busy));
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
    parameter int ADDR_W = nvw_pkg::ADDR_W,
    parameter int DATA_W = nvw_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              erase,
    input  logic              bulk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];
    logic              total;

    assign total = bulk && erase && (addr == '0);

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic hit;
        assign hit = commit && (total || (addr == ADDR_W'(i)));

        always_comb begin
            mem_d[i] = mem_q[i];
            if (hit)
                mem_d[i] = erase ? {DATA_W{1'b1}} : (mem_q[i] & wdata);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= {DATA_W{1'b1}};
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R6: single-word erase leaves all ones
    p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && erase) |=> (mem_q[$past(addr)] == {DATA_W{1'b1}}));

    // R7: write is an AND with the frame data
    p_write_and_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !erase) |=>
            (mem_q[$past(addr)] == ($past(mem_q[addr]) & $past(wdata))));

    // R9: bulk erase reaches both ends of the array
    p_bulk_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && total) |=> ((mem_q[0] == {DATA_W{1'b1}}) &&
                               (mem_q[WORDS-1] == {DATA_W{1'b1}})));
endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
    import nvw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              bulk_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              err
);
    logic [FRAME_W-1:0] frame;
    logic               shift_en, commit, op_erase, op_bulk;
    logic [DATA_W-1:0]  f_data;
    logic [ADDR_W-1:0]  f_addr;
    logic               f_cb;

    // frame layout: data byte above the control byte; control MSB is the arm bit
    assign f_data = frame[FRAME_W-1 -: DATA_W];
    assign f_cb   = frame[ADDR_W];
    assign f_addr = frame[ADDR_W-1:0];

    nvw_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi      (sdi),
        .frame    (frame)
    );

    nvw_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .bulk_en  (bulk_en),
        .cb       (f_cb),
        .shift_en (shift_en),
        .commit   (commit),
        .op_erase (op_erase),
        .op_bulk  (op_bulk),
        .busy     (busy),
        .err      (err)
    );

    nvw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .erase   (op_erase),
        .bulk    (op_bulk),
        .addr    (f_addr),
        .wdata   (f_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R11: the array is only committed from the busy state
    p_commit_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    // R3/R11: shifting never overlaps a selection
    p_no_shift_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !shift_en);
endmodule

// File: tb/nvw_ctrl_tb.sv
module nvw_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, bulk_en = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, err;

    int n_chk = 0, n_fail = 0, pending = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] a;
        string      tag;
    } item_t;
    item_t sb_q[$];

    logic [7:0] exp_mem [WORDS];
    logic [7:0] cur_data;
    logic [7:0] cur_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvw_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .bulk_en(bulk_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: queue a word to compare against the model
    task automatic push_word(input logic [6:0] a, input string tag);
        item_t it;
        it.a = a;
        it.tag = tag;
        pending++;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        wait (pending == 0);
    endtask

    // monitor side: pop, read the port, compare
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            @(negedge clk);
            rd_addr = it.a;
            #1;
            check({it.tag, " R12 word"}, rd_data, exp_mem[it.a]);
            pending--;
        end
    end

    task automatic pulse();
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
    endtask

    // R2: data byte first, then control byte, each MSB first
    task automatic load_frame(input logic [7:0] data, input logic cb, input logic [6:0] a);
        logic [15:0] f;
        cur_data = data;
        cur_ctl  = {cb, a};
        f = {data, cb, a};
        @(negedge clk);
        cs_n = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            sdi = f[i];
            @(negedge clk);
            pulse();
        end
    endtask

    task automatic run_op(input logic erase, input logic bulk, input bit extra_clk);
        bit armed;
        armed = cur_ctl[7];
        @(negedge clk);
        sdi = erase;
        bulk_en = bulk;
        cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
        @(negedge clk);
        check(armed ? "R5 busy after start pulse" : "R3 unarmed no busy", busy, armed);
        if (extra_clk) begin
            pulse();
            check("R5 busy through extra sclk", busy, armed);
        end
        cs_n = 1'b1;
        @(negedge clk);
        check("R5 busy drops after deselect", busy, 1'b0);
        bulk_en = 1'b0;
        if (armed) begin
            if (erase && bulk && cur_ctl[6:0] == 7'd0) begin
                for (int k = 0; k < WORDS; k++) exp_mem[k] = 8'hFF;
            end else if (erase) begin
                exp_mem[cur_ctl[6:0]] = 8'hFF;
            end else begin
                exp_mem[cur_ctl[6:0]] = exp_mem[cur_ctl[6:0]] & cur_data;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < WORDS; k++) exp_mem[k] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy", busy, 1'b0);
        check("R1 err", err, 1'b0);
        push_word(7'd0, "R1");
        push_word(7'd64, "R1");
        push_word(7'd127, "R1");
        drain();

        // R2 R4 R7: separate write to word 5
        load_frame(8'hA5, 1'b1, 7'd5);
        run_op(1'b0, 1'b0, 1'b0);
        push_word(7'd5, "R2 R7 write");
        push_word(7'd4, "R11 neighbour");
        drain();

        // R7: second write ANDs
        load_frame(8'h0F, 1'b1, 7'd5);
        run_op(1'b0, 1'b0, 1'b0);
        push_word(7'd5, "R7 and");
        drain();

        // R4 R6 R8: erase then write, no new frame
        load_frame(8'h3C, 1'b1, 7'd5);
        run_op(1'b1, 1'b0, 1'b0);
        push_word(7'd5, "R4 R6 erase");
        drain();
        run_op(1'b0, 1'b0, 1'b0);
        push_word(7'd5, "R8 write after erase");
        push_word(7'd6, "R11 neighbour");
        drain();

        // R3: arm bit clear
        load_frame(8'h00, 1'b0, 7'd9);
        run_op(1'b0, 1'b0, 1'b0);
        push_word(7'd9, "R3 unchanged");
        drain();

        // R10: sdi moves before the start pulse
        load_frame(8'h00, 1'b1, 7'd10);
        @(negedge clk);
        sdi = 1'b0;
        cs_n = 1'b0;
        @(negedge clk);
        sdi = 1'b1;
        @(negedge clk);
        check("R10 err raised", err, 1'b1);
        pulse();
        @(negedge clk);
        check("R10 no busy", busy, 1'b0);
        cs_n = 1'b1;
        @(negedge clk);
        check("R10 err cleared", err, 1'b0);
        push_word(7'd10, "R10 unchanged");
        drain();

        // R5 R11: extra sclk while busy leaves frame and result intact
        load_frame(8'h55, 1'b1, 7'd127);
        run_op(1'b0, 1'b0, 1'b1);
        push_word(7'd127, "R11 busy clocks ignored");
        drain();
        load_frame(8'h81, 1'b1, 7'd40);
        run_op(1'b0, 1'b0, 1'b0);
        load_frame(8'hF0, 1'b1, 7'd0);
        run_op(1'b0, 1'b0, 1'b0);

        // R9: bulk erase
        load_frame(8'h00, 1'b1, 7'd0);
        run_op(1'b1, 1'b1, 1'b0);
        push_word(7'd0, "R9 bulk");
        push_word(7'd40, "R9 bulk");
        push_word(7'd127, "R9 bulk");
        push_word(7'd5, "R9 bulk");
        drain();

        // R9: bulk pin with a write is a normal write
        load_frame(8'h12, 1'b1, 7'd0);
        run_op(1'b0, 1'b1, 1'b0);
        push_word(7'd0, "R9 bulk write");
        push_word(7'd40, "R9 bulk write other");
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule